// File: doc/BRIEF.md
# Integer Pipeline Hazard and Forwarding Control

This block supplies the control side of a four-stage in-order integer pipeline. The stages are instruction fetch, decode, a merged execute/memory stage, and writeback. The block looks at three things: the source registers of the instruction in decode, the destination of the instruction in execute, and the destination of the instruction in writeback. From these it picks the operand source for each of the two ALU inputs. The selects are registered into the execute stage together with the instruction. Because execute and memory are one stage, only two bypass paths exist: the result of the execute stage, one slot ahead, and the result in writeback, two slots ahead.

The same block also produces the pipeline-movement signals. A load in execute whose destination the decode instruction reads holds the PC and the fetch/decode register, and puts one bubble into execute. It does this even when a bypass could have supplied the value. A long-latency floating-point operation that has not yet retired holds the integer pipe the same way, so state changes stay in program order. A redirect resolved in execute kills the fetch and decode stages. A redirect always wins over any hold, so fetch can take the new target at once.

All outputs are combinational functions of the current inputs. The clock and reset are used only by the embedded checks.

Top module: `hzd_fwd_ctrl`

## Requirements
- R1: Operand select encoding is 0 = register file, 1 = execute-stage result, 2 = writeback result. A used source equal to a nonzero execute destination whose write flag is set selects 1.
- R2: A used source that matches only a nonzero writeback destination whose write flag is set selects 2.
- R3: When both execute and writeback match the same source, the select is 1, because the younger result wins.
- R4: Register 0 is never forwarded. A source of 0 always selects 0.
- R5: A source marked unused, or a producer whose write flag is clear (a killed or bubbled instruction), never causes a forward.
- R6: A load in execute with its write flag set and a nonzero destination that matches a used decode source raises pc_hold, ifid_hold and ex_bubble together. This happens even when writeback also matches.
- R7: A load with no matching used source in decode causes no hold. A load already in writeback is served by forwarding (select 2) without a hold.
- R8: ex_redirect raises if_kill and id_kill, with all holds low.
- R9: fpu_busy with no redirect raises pc_hold, ifid_hold and ex_bubble.
- R10: A redirect together with a load-use or FP-busy condition gives only the kill outputs. All holds stay low.
- R11: With no hazard, redirect or FP-busy condition, every hold and kill output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the embedded checks |
| rst_n | input | 1 | Active-low reset, used only by the embedded checks |
| id_rs1 | input | RA_W | First source register of the instruction in decode |
| id_rs2 | input | RA_W | Second source register of the instruction in decode |
| id_rs1_used | input | 1 | Decode instruction reads its first source |
| id_rs2_used | input | 1 | Decode instruction reads its second source |
| ex_rd | input | RA_W | Destination of the instruction in execute |
| ex_rd_wen | input | 1 | Execute instruction writes a register (clear for killed or bubbled instructions) |
| ex_is_load | input | 1 | Execute instruction is a load |
| wb_rd | input | RA_W | Destination of the instruction in writeback |
| wb_rd_wen | input | 1 | Writeback instruction writes a register |
| ex_redirect | input | 1 | Branch or jump resolved in execute redirects fetch |
| fpu_busy | input | 1 | A floating-point operation has not yet retired |
| fwd_a | output | 2 | Operand A source select |
| fwd_b | output | 2 | Operand B source select |
| pc_hold | output | 1 | Keep the PC |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| ex_bubble | output | 1 | Load a bubble into execute |
| if_kill | output | 1 | Discard the instruction in fetch |
| id_kill | output | 1 | Discard the instruction in decode |

## Verification
The bench targets the cases where both producers match the same source. A design with the priority reversed would feed stale writeback data; the bench sees this as a select of 2 where 1 is expected. It drives register 0 as source and destination. A design without the zero guard would bypass a value into a hardwired-zero operand. It also drives loads whose dependent operand is unused, killed, or two slots behind. A design that stalls on these would lose cycles, and one that misses the true load-use pair would read the old register value. Finally, it combines redirects with load-use and FP-busy conditions. A design where a hold wins over the kill would freeze fetch on a wrong-path address.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_RF = 2'd0,
    FWD_EX = 2'd1,
    FWD_WB = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/fwd_pick.sv
module fwd_pick
  import hzd_pkg::*;
#(
  parameter int RA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_used,
  input  logic [RA_W-1:0] src_reg,
  input  logic [RA_W-1:0] ex_rd,
  input  logic            ex_wen,
  input  logic [RA_W-1:0] wb_rd,
  input  logic            wb_wen,
  output fwd_sel_e        sel,
  output logic            ex_hit,
  output logic            wb_hit
);
  // A producer matches only if it really writes, targets a nonzero register
  // and the consumer actually reads that operand.
  function automatic logic producer_match(input logic used, input logic [RA_W-1:0] rs,
                                          input logic [RA_W-1:0] rd, input logic wen);
    return used && wen && (rd != '0) && (rd == rs);
  endfunction

  assign ex_hit = producer_match(src_used, src_reg, ex_rd, ex_wen);
  assign wb_hit = producer_match(src_used, src_reg, wb_rd, wb_wen);

  always_comb begin
    if (ex_hit)      sel = FWD_EX;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  // R4
  x0_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_reg == '0) |-> (sel == FWD_RF));

  // R3
  young_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_hit && wb_hit) |-> (sel == FWD_EX));

  // R5
  unused_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !src_used |-> (sel == FWD_RF));
endmodule

// File: rtl/hazard_core.sv
module hazard_core #(
  parameter int RA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RA_W-1:0] id_rs1,
  input  logic [RA_W-1:0] id_rs2,
  input  logic            id_rs1_used,
  input  logic            id_rs2_used,
  input  logic [RA_W-1:0] ex_rd,
  input  logic            ex_wen,
  input  logic            ex_is_load,
  input  logic            redirect,
  input  logic            fpu_busy,
  output logic            load_use,
  output logic            hold_req,
  output logic            pc_hold,
  output logic            ifid_hold,
  output logic            ex_bubble,
  output logic            if_kill,
  output logic            id_kill
);
  // Load-use test ignores whether a bypass could have covered it.
  function automatic logic reads_reg(input logic used, input logic [RA_W-1:0] rs,
                                     input logic [RA_W-1:0] rd);
    return used && (rs == rd);
  endfunction

  assign load_use = ex_is_load && ex_wen && (ex_rd != '0) &&
                    (reads_reg(id_rs1_used, id_rs1, ex_rd) ||
                     reads_reg(id_rs2_used, id_rs2, ex_rd));

  assign hold_req  = load_use || fpu_busy;

  // Redirect takes precedence over every hold.
  assign if_kill   = redirect;
  assign id_kill   = redirect;
  assign pc_hold   = hold_req && !redirect;
  assign ifid_hold = hold_req && !redirect;
  assign ex_bubble = hold_req && !redirect;

  // R10
  kill_over_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_kill |-> (!pc_hold && !ifid_hold && !ex_bubble));

  // R9
  fpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fpu_busy && !redirect) |-> (pc_hold && ifid_hold && ex_bubble));

  // R6
  load_use_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_use && !if_kill) |-> (pc_hold && ex_bubble));

  // R8
  kill_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_kill == id_kill));
endmodule

// File: rtl/hzd_fwd_ctrl.sv
module hzd_fwd_ctrl
  import hzd_pkg::*;
#(
  parameter int RA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RA_W-1:0] id_rs1,
  input  logic [RA_W-1:0] id_rs2,
  input  logic            id_rs1_used,
  input  logic            id_rs2_used,
  input  logic [RA_W-1:0] ex_rd,
  input  logic            ex_rd_wen,
  input  logic            ex_is_load,
  input  logic [RA_W-1:0] wb_rd,
  input  logic            wb_rd_wen,
  input  logic            ex_redirect,
  input  logic            fpu_busy,
  output logic [1:0]      fwd_a,
  output logic [1:0]      fwd_b,
  output logic            pc_hold,
  output logic            ifid_hold,
  output logic            ex_bubble,
  output logic            if_kill,
  output logic            id_kill
);
  localparam int N_OPS = 2;

  logic [RA_W-1:0] op_reg  [N_OPS];
  logic            op_used [N_OPS];
  fwd_sel_e        op_sel  [N_OPS];
  logic            op_ex_hit [N_OPS];
  logic            op_wb_hit [N_OPS];
  logic            load_use;
  logic            hold_req;

  assign op_reg[0]  = id_rs1;
  assign op_reg[1]  = id_rs2;
  assign op_used[0] = id_rs1_used;
  assign op_used[1] = id_rs2_used;

  for (genvar k = 0; k < N_OPS; k++) begin : g_op
    fwd_pick #(.RA_W(RA_W)) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_used (op_used[k]),
      .src_reg  (op_reg[k]),
      .ex_rd    (ex_rd),
      .ex_wen   (ex_rd_wen),
      .wb_rd    (wb_rd),
      .wb_wen   (wb_rd_wen),
      .sel      (op_sel[k]),
      .ex_hit   (op_ex_hit[k]),
      .wb_hit   (op_wb_hit[k])
    );
  end

  assign fwd_a = op_sel[0];
  assign fwd_b = op_sel[1];

  hazard_core #(.RA_W(RA_W)) u_hz (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_rs1      (id_rs1),
    .id_rs2      (id_rs2),
    .id_rs1_used (id_rs1_used),
    .id_rs2_used (id_rs2_used),
    .ex_rd       (ex_rd),
    .ex_wen      (ex_rd_wen),
    .ex_is_load  (ex_is_load),
    .redirect    (ex_redirect),
    .fpu_busy    (fpu_busy),
    .load_use    (load_use),
    .hold_req    (hold_req),
    .pc_hold     (pc_hold),
    .ifid_hold   (ifid_hold),
    .ex_bubble   (ex_bubble),
    .if_kill     (if_kill),
    .id_kill     (id_kill)
  );

  // R5
  dead_producer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_rd_wen && !wb_rd_wen) |-> (fwd_a == 2'd0 && fwd_b == 2'd0));

  // R6
  load_hit_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_use |-> (op_ex_hit[0] || op_ex_hit[1]));

  // R11
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_req && !ex_redirect) |-> !(pc_hold || ifid_hold || ex_bubble || if_kill || id_kill));

  // R2
  wb_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wb_hit[0] && !op_ex_hit[0]) |-> (fwd_a == 2'd2));
endmodule

// File: tb/test_hzd_fwd_ctrl.sv
module test_hzd_fwd_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [4:0] id_rs1, id_rs2, ex_rd, wb_rd;
  logic id_rs1_used, id_rs2_used, ex_rd_wen, ex_is_load, wb_rd_wen, ex_redirect, fpu_busy;
  logic [1:0] fwd_a, fwd_b;
  logic pc_hold, ifid_hold, ex_bubble, if_kill, id_kill;

  hzd_fwd_ctrl #(.RA_W(5)) i_hzd_fwd_ctrl (
    .clk(clk), .rst_n(rst_n),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
    .ex_rd(ex_rd), .ex_rd_wen(ex_rd_wen), .ex_is_load(ex_is_load),
    .wb_rd(wb_rd), .wb_rd_wen(wb_rd_wen), .ex_redirect(ex_redirect), .fpu_busy(fpu_busy),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
    .ex_bubble(ex_bubble), .if_kill(if_kill), .id_kill(id_kill)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // ctl = {pc_hold, ifid_hold, ex_bubble, if_kill, id_kill}
  typedef struct packed {
    logic [4:0] rs1, rs2;
    logic u1, u2;
    logic [4:0] exrd;
    logic exw, exld;
    logic [4:0] wbrd;
    logic wbw, redir, fpb;
    logic [1:0] ea, eb;
    logic [4:0] ctl;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{5'd1, 5'd2, 1'b1,1'b1, 5'd3, 1'b1,1'b0, 5'd4, 1'b1,1'b0,1'b0, 2'd0,2'd0, 5'b00000, 8'd11}, // R11 quiet
    '{5'd5, 5'd2, 1'b1,1'b1, 5'd5, 1'b1,1'b0, 5'd4, 1'b1,1'b0,1'b0, 2'd1,2'd0, 5'b00000, 8'd1},  // R1 A from EX
    '{5'd1, 5'd6, 1'b1,1'b1, 5'd6, 1'b1,1'b0, 5'd9, 1'b1,1'b0,1'b0, 2'd0,2'd1, 5'b00000, 8'd1},  // R1 B from EX
    '{5'd7, 5'd2, 1'b1,1'b1, 5'd3, 1'b1,1'b0, 5'd7, 1'b1,1'b0,1'b0, 2'd2,2'd0, 5'b00000, 8'd2},  // R2 A from WB
    '{5'd8, 5'd8, 1'b1,1'b1, 5'd3, 1'b1,1'b0, 5'd8, 1'b1,1'b0,1'b0, 2'd2,2'd2, 5'b00000, 8'd2},  // R2 both WB
    '{5'd9, 5'd9, 1'b1,1'b1, 5'd9, 1'b1,1'b0, 5'd9, 1'b1,1'b0,1'b0, 2'd1,2'd1, 5'b00000, 8'd3},  // R3 EX over WB
    '{5'd10,5'd11,1'b1,1'b1, 5'd10,1'b1,1'b0, 5'd11,1'b1,1'b0,1'b0, 2'd1,2'd2, 5'b00000, 8'd3},  // R3 mixed
    '{5'd0, 5'd0, 1'b1,1'b1, 5'd0, 1'b1,1'b0, 5'd0, 1'b1,1'b0,1'b0, 2'd0,2'd0, 5'b00000, 8'd4},  // R4 x0
    '{5'd12,5'd12,1'b0,1'b0, 5'd12,1'b1,1'b0, 5'd12,1'b1,1'b0,1'b0, 2'd0,2'd0, 5'b00000, 8'd5},  // R5 unused
    '{5'd13,5'd14,1'b1,1'b1, 5'd13,1'b0,1'b0, 5'd14,1'b0,1'b0,1'b0, 2'd0,2'd0, 5'b00000, 8'd5},  // R5 killed producers
    '{5'd15,5'd1, 1'b1,1'b1, 5'd15,1'b1,1'b1, 5'd2, 1'b1,1'b0,1'b0, 2'd1,2'd0, 5'b11100, 8'd6},  // R6 load-use A
    '{5'd1, 5'd16,1'b1,1'b1, 5'd16,1'b1,1'b1, 5'd16,1'b1,1'b0,1'b0, 2'd0,2'd1, 5'b11100, 8'd6},  // R6 load-use B, WB also
    '{5'd17,5'd18,1'b1,1'b1, 5'd19,1'b1,1'b1, 5'd2, 1'b1,1'b0,1'b0, 2'd0,2'd0, 5'b00000, 8'd7},  // R7 no dependency
    '{5'd19,5'd18,1'b0,1'b1, 5'd19,1'b1,1'b1, 5'd2, 1'b1,1'b0,1'b0, 2'd0,2'd0, 5'b00000, 8'd7},  // R7 match but unused
    '{5'd0, 5'd2, 1'b1,1'b1, 5'd0, 1'b1,1'b1, 5'd4, 1'b1,1'b0,1'b0, 2'd0,2'd0, 5'b00000, 8'd6},  // R6 load to x0
    '{5'd20,5'd2, 1'b1,1'b1, 5'd20,1'b0,1'b1, 5'd4, 1'b1,1'b0,1'b0, 2'd0,2'd0, 5'b00000, 8'd6},  // R6 killed load
    '{5'd21,5'd2, 1'b1,1'b1, 5'd3, 1'b1,1'b0, 5'd21,1'b1,1'b0,1'b0, 2'd2,2'd0, 5'b00000, 8'd7},  // R7 load in WB
    '{5'd1, 5'd2, 1'b1,1'b1, 5'd3, 1'b1,1'b0, 5'd4, 1'b1,1'b1,1'b0, 2'd0,2'd0, 5'b00011, 8'd8},  // R8 redirect
    '{5'd1, 5'd2, 1'b1,1'b1, 5'd3, 1'b1,1'b0, 5'd4, 1'b1,1'b0,1'b1, 2'd0,2'd0, 5'b11100, 8'd9},  // R9 fpu busy
    '{5'd1, 5'd2, 1'b1,1'b1, 5'd3, 1'b1,1'b0, 5'd4, 1'b1,1'b1,1'b1, 2'd0,2'd0, 5'b00011, 8'd10}, // R10 redirect+fpu
    '{5'd15,5'd1, 1'b1,1'b1, 5'd15,1'b1,1'b1, 5'd2, 1'b1,1'b1,1'b0, 2'd1,2'd0, 5'b00011, 8'd10}, // R10 redirect+load-use
    '{5'd15,5'd1, 1'b1,1'b1, 5'd15,1'b1,1'b1, 5'd2, 1'b1,1'b0,1'b1, 2'd1,2'd0, 5'b11100, 8'd9}   // R9 fpu+load-use
  };

  function automatic logic [1:0] ref_sel(input logic used, input logic [4:0] rs,
                                         input logic [4:0] erd, input logic ew,
                                         input logic [4:0] wrd, input logic ww);
    if (!used || rs == 5'd0) return 2'd0;
    if (ew && erd == rs) return 2'd1;
    if (ww && wrd == rs) return 2'd2;
    return 2'd0;
  endfunction

  task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual fa=%0d fb=%0d ctl=%05b expected fa=%0d fb=%0d ctl=%05b",
               tag, got[8:7], got[6:5], got[4:0], exp[8:7], exp[6:5], exp[4:0]);
    end
  endtask

  function automatic logic [8:0] outs();
    return {fwd_a, fwd_b, pc_hold, ifid_hold, ex_bubble, if_kill, id_kill};
  endfunction

  task automatic drive(input vec_t v);
    @(negedge clk);
    id_rs1 = v.rs1; id_rs2 = v.rs2; id_rs1_used = v.u1; id_rs2_used = v.u2;
    ex_rd = v.exrd; ex_rd_wen = v.exw; ex_is_load = v.exld;
    wb_rd = v.wbrd; wb_rd_wen = v.wbw; ex_redirect = v.redir; fpu_busy = v.fpb;
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    vec_t z;
    z = '0;
    drive(z);
    // R11 reset state: idle inputs give idle outputs
    check("R11 reset", outs(), 9'd0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), outs(),
            {VECS[i].ea, VECS[i].eb, VECS[i].ctl});
    end

    // R1 R2 R4 sweep: every register index as EX and WB destination
    for (int r = 0; r < 32; r++) begin
      vec_t v;
      v = '0;
      v.rs1 = 5'(r); v.rs2 = 5'(31 - r); v.u1 = 1'b1; v.u2 = 1'b1;
      v.exrd = 5'(r); v.exw = 1'b1; v.wbrd = 5'(31 - r); v.wbw = 1'b1;
      drive(v);
      check($sformatf("R1 R2 R4 sweep r=%0d", r), outs(),
            {ref_sel(1'b1, 5'(r), 5'(r), 1'b1, 5'(31 - r), 1'b1),
             ref_sel(1'b1, 5'(31 - r), 5'(r), 1'b1, 5'(31 - r), 1'b1), 5'b00000});
    end

    // R6 R7 back-to-back: load-use stall, then the load moves to WB
    begin
      vec_t v;
      v = '0;
      v.rs1 = 5'd7; v.u1 = 1'b1; v.exrd = 5'd7; v.exw = 1'b1; v.exld = 1'b1;
      drive(v);
      check("R6 cycle1 stall", outs(), {2'd1, 2'd0, 5'b11100});
      v.exw = 1'b0; v.exld = 1'b0; v.wbrd = 5'd7; v.wbw = 1'b1;
      drive(v);
      check("R7 cycle2 wb forward", outs(), {2'd2, 2'd0, 5'b00000});
    end

    drive(z);
    check("R11 idle end", outs(), 9'd0);
    finish_run();
  end
endmodule